// File: doc/BRIEF.md
# Multi-Channel DAC Command Register Controller

This block sits behind the command port of a 32-channel, 14-bit converter. It holds a data, a gain and an offset register for each channel, plus one shared clear-code register. Each command word has a 2-bit register-select field, a 5-bit address field and a 14-bit data field. When the select field is non-zero, the word writes the register of the channel that the address field names. When the select field is zero, the word is a special-function command. The address field then selects a no-op, a clear-code write, a software clear, a software power-down, a software power-up or a software reset.

An active-low `busy_n` output goes low while a command is in progress. Each command has its own busy length. While `busy_n` is low, new commands are ignored. A hardware clear input starts the same channel-by-channel clear walk as the software clear. A hardware power-down input is ORed with the software power-down flag. While the block is powered down, every register write and every clear is dropped and all register contents are kept. A read port returns the three registers of any channel, and the clear code is visible on its own output.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Register writes use select codes 01 (gain), 10 (offset) and 11 (data), and take effect at the accepting edge without lowering `busy_n`. Special-function commands use select 00 and are decoded from the address field: 00000 no-op, 00001 clear-code write, 00010 software clear, 01000 power-down, 01001 power-up, 01111 software reset.
- R2: A clear-code write stores `cmd_data` into the clear code at the accepting edge and does not lower `busy_n`.
- R3: A software clear lowers `busy_n` for exactly NCH cycles, starting on the cycle after acceptance. It writes the clear code into one channel per cycle, in the order 0, 1, … 31, and channel 31 is written on the last low cycle.
- R4: When `hw_clr_n` is low while the block is idle and not powered down, the same clear walk starts. It takes priority over a command offered in that cycle, and that command is dropped.
- R5: A no-op, and any select-00 address not listed in R1, lowers `busy_n` for exactly one cycle and changes no register.
- R6: A power-down command sets the software flag and lowers `busy_n` for one cycle. `pd_active` equals `hw_pd` OR that flag. While `pd_active` is high, register writes, clear-code writes, software clears and hardware clears have no effect.
- R7: A power-up command clears only the software flag and lowers `busy_n` for PWRUP_CYCLES cycles. It cannot override `hw_pd`.
- R8: A software reset, accepted even while powered down, sets every gain to all ones and every offset, data register and the clear code to zero. It also clears the software flag and lowers `busy_n` for RESET_CYCLES cycles.
- R9: Any command offered while `busy_n` is low is ignored.
- R10: The data field has no effect on no-op, clear, power-down, power-up and reset commands.
- R11: After `rst_n`, `busy_n` is 1, `pd_active` follows `hw_pd`, gains are all ones, and offsets, data registers and the clear code are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_sel | input | 2 | Register-select field |
| cmd_addr | input | 5 | Address / channel field |
| cmd_data | input | 14 | Data field |
| hw_clr_n | input | 1 | Hardware clear, active low |
| hw_pd | input | 1 | Hardware power-down |
| rd_chan | input | 5 | Channel shown on the read port |
| busy_n | output | 1 | Low while a command runs |
| pd_active | output | 1 | Powered-down state |
| clr_code | output | 14 | Clear-code register |
| rd_data | output | 14 | Data register of `rd_chan` |
| rd_gain | output | 14 | Gain register of `rd_chan` |
| rd_offset | output | 14 | Offset register of `rd_chan` |

## Verification
Each channel's data register is first loaded with a distinct value. This makes it possible to see which channels a clear walk overwrote, and in which cycle. Clears are started from the command port, from the hardware pin, and from both in the same cycle, which separates the priority rule from plain decoding. Writes, clears and clear-code writes are offered under software power-down, under hardware power-down and while `busy_n` is low, which shows whether each lockout holds on its own. No-ops, unlisted codes and don't-care data fields carrying all-ones values confirm that only the listed codes change state.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    OP_NOP, OP_CLRWR, OP_SCLR, OP_PDN, OP_PUP, OP_SRST, OP_REGWR
  } op_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WALK, SQ_WAIT} sq_e;

  // select 00 picks a special function by address; any other select is a register write
  function automatic op_e decode_op(input logic [SEL_W-1:0] sel,
                                    input logic [ADDR_W-1:0] addr);
    if (sel != '0) return OP_REGWR;
    case (addr)
      5'h01:   return OP_CLRWR;
      5'h02:   return OP_SCLR;
      5'h08:   return OP_PDN;
      5'h09:   return OP_PUP;
      5'h0F:   return OP_SRST;
      default: return OP_NOP;   // listed no-op and every unlisted code
    endcase
  endfunction
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic              idle,
  input  logic              pd,
  input  logic              hw_clr_n,
  input  logic              cmd_valid,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              walk_start,
  output logic              clrwr_fire,
  output logic              nop_fire,
  output logic              pdn_fire,
  output logic              pup_fire,
  output logic              srst_fire,
  output logic              gain_we,
  output logic              offs_we,
  output logic              data_we
);
  op_e  op;
  logic hw_go, cmd_go, sclr_fire, regwr;

  always_comb begin
    op        = decode_op(cmd_sel, cmd_addr);
    hw_go     = idle && !hw_clr_n && !pd;
    cmd_go    = idle && !hw_go && cmd_valid;
    sclr_fire = cmd_go && (op == OP_SCLR) && !pd;
    walk_start = hw_go || sclr_fire;
    clrwr_fire = cmd_go && (op == OP_CLRWR) && !pd;
    nop_fire   = cmd_go && (op == OP_NOP);
    pdn_fire   = cmd_go && (op == OP_PDN);
    pup_fire   = cmd_go && (op == OP_PUP);
    srst_fire  = cmd_go && (op == OP_SRST);
    regwr      = cmd_go && (op == OP_REGWR) && !pd;
    gain_we    = regwr && (cmd_sel == 2'b01);
    offs_we    = regwr && (cmd_sel == 2'b10);
    data_we    = regwr && (cmd_sel == 2'b11);
  end
endmodule

// File: rtl/dac_cmd_seq.sv
module dac_cmd_seq
  import dac_cmd_pkg::*;
#(
  parameter int NCH          = 32,
  parameter int PWRUP_CYCLES = 40,
  parameter int RESET_CYCLES = 60,
  localparam int CW   = $clog2(NCH),
  localparam int MAXC = (PWRUP_CYCLES > RESET_CYCLES) ? PWRUP_CYCLES : RESET_CYCLES,
  localparam int TW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          walk_start,
  input  logic          nop_fire,
  input  logic          pdn_fire,
  input  logic          pup_fire,
  input  logic          srst_fire,
  output logic          idle,
  output logic          busy_n,
  output logic          sw_pd,
  output logic          walk_en,
  output logic [CW-1:0] walk_idx
);
  sq_e           state;
  logic [TW-1:0] tmr;

  // busy-low length minus one, as loaded into the wait timer
  function automatic logic [TW-1:0] wait_load(input logic is_rst, input logic is_pup);
    if (is_rst) return TW'(RESET_CYCLES - 1);
    if (is_pup) return TW'(PWRUP_CYCLES - 1);
    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      tmr      <= '0;
      walk_idx <= '0;
      sw_pd    <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (walk_start) begin
            state    <= SQ_WALK;
            walk_idx <= '0;
          end else if (srst_fire || pup_fire || pdn_fire || nop_fire) begin
            state <= SQ_WAIT;
            tmr   <= wait_load(srst_fire, pup_fire);
          end
          if (pdn_fire) sw_pd <= 1'b1;
          if (pup_fire || srst_fire) sw_pd <= 1'b0;
        end
        SQ_WALK: begin
          walk_idx <= walk_idx + 1'b1;
          if (walk_idx == CW'(NCH - 1)) state <= SQ_IDLE;
        end
        SQ_WAIT: begin
          if (tmr == '0) state <= SQ_IDLE;
          else           tmr   <= tmr - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign idle    = (state == SQ_IDLE);
  assign busy_n  = idle;
  assign walk_en = (state == SQ_WALK);

  assert_walk_begins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> (walk_en && walk_idx == '0 && !busy_n));
  assert_walk_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_en && walk_idx == CW'(NCH - 1)) |=> busy_n);
  assert_nop_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nop_fire |=> !busy_n ##1 busy_n);
  assert_pdn_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_fire |=> sw_pd);
  assert_pup_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pup_fire |=> !sw_pd);
endmodule

// File: rtl/dac_cmd_regbank.sv
module dac_cmd_regbank #(
  parameter int NCH = 32,
  parameter int DW  = 14,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          clrwr,
  input  logic          data_we,
  input  logic          gain_we,
  input  logic          offs_we,
  input  logic [CW-1:0] wr_chan,
  input  logic [DW-1:0] wr_val,
  input  logic          walk_en,
  input  logic [CW-1:0] walk_idx,
  input  logic [CW-1:0] rd_chan,
  output logic [DW-1:0] clr_code,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_gain,
  output logic [DW-1:0] rd_offs
);
  function automatic logic [DW-1:0] gain_default();
    return '1;   // full scale
  endfunction

  logic [DW-1:0] data_arr [NCH];
  logic [DW-1:0] gain_arr [NCH];
  logic [DW-1:0] offs_arr [NCH];
  logic [DW-1:0] clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     clr_q <= '0;
    else if (srst)  clr_q <= '0;
    else if (clrwr) clr_q <= wr_val;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] d_q, g_q, o_q;
    logic          hit_wr, hit_walk;
    assign hit_wr   = (wr_chan == CW'(c));
    assign hit_walk = walk_en && (walk_idx == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        g_q <= gain_default();
        o_q <= '0;
      end else if (srst) begin
        d_q <= '0;
        g_q <= gain_default();
        o_q <= '0;
      end else begin
        if (hit_walk)               d_q <= clr_q;
        else if (data_we && hit_wr) d_q <= wr_val;
        if (gain_we && hit_wr) g_q <= wr_val;
        if (offs_we && hit_wr) o_q <= wr_val;
      end
    end

    assign data_arr[c] = d_q;
    assign gain_arr[c] = g_q;
    assign offs_arr[c] = o_q;
  end

  assign clr_code = clr_q;
  assign rd_data  = data_arr[rd_chan];
  assign rd_gain  = gain_arr[rd_chan];
  assign rd_offs  = offs_arr[rd_chan];

  assert_clrwr_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clrwr && !srst) |=> (clr_code == $past(wr_val)));
  assert_srst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (clr_code == '0));
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int NCH          = 32,
  parameter int DW           = 14,
  parameter int PWRUP_CYCLES = 40,
  parameter int RESET_CYCLES = 60,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic              hw_clr_n,
  input  logic              hw_pd,
  input  logic [CW-1:0]     rd_chan,
  output logic              busy_n,
  output logic              pd_active,
  output logic [DW-1:0]     clr_code,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     rd_gain,
  output logic [DW-1:0]     rd_offset
);
  logic          idle, sw_pd, walk_en;
  logic [CW-1:0] walk_idx;
  logic walk_start, clrwr_fire, nop_fire, pdn_fire, pup_fire, srst_fire;
  logic gain_we, offs_we, data_we;

  assign pd_active = hw_pd | sw_pd;

  dac_cmd_decode u_dec (
    .idle(idle), .pd(pd_active), .hw_clr_n(hw_clr_n), .cmd_valid(cmd_valid),
    .cmd_sel(cmd_sel), .cmd_addr(cmd_addr),
    .walk_start(walk_start), .clrwr_fire(clrwr_fire), .nop_fire(nop_fire),
    .pdn_fire(pdn_fire), .pup_fire(pup_fire), .srst_fire(srst_fire),
    .gain_we(gain_we), .offs_we(offs_we), .data_we(data_we)
  );

  dac_cmd_seq #(.NCH(NCH), .PWRUP_CYCLES(PWRUP_CYCLES), .RESET_CYCLES(RESET_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .nop_fire(nop_fire),
    .pdn_fire(pdn_fire), .pup_fire(pup_fire), .srst_fire(srst_fire),
    .idle(idle), .busy_n(busy_n), .sw_pd(sw_pd), .walk_en(walk_en), .walk_idx(walk_idx)
  );

  dac_cmd_regbank #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .srst(srst_fire), .clrwr(clrwr_fire),
    .data_we(data_we), .gain_we(gain_we), .offs_we(offs_we),
    .wr_chan(cmd_addr[CW-1:0]), .wr_val(cmd_data),
    .walk_en(walk_en), .walk_idx(walk_idx), .rd_chan(rd_chan),
    .clr_code(clr_code), .rd_data(rd_data), .rd_gain(rd_gain), .rd_offs(rd_offset)
  );

  // a busy sequencer accepts nothing, so the clear code cannot move
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> $stable(clr_code));
  // only a reset may touch the clear code while powered down
  assert_pd_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !srst_fire) |=> $stable(clr_code));
  assert_pd_no_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && busy_n) |=> !walk_en);
endmodule

// File: tb/dac_cmd_ctrl_bench.sv
module dac_cmd_ctrl_bench;
  localparam int NCH = 32, DW = 14, PWRUP = 40, RSTC = 60;

  logic clk = 0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n = 0, cmd_valid = 0, hw_clr_n = 1, hw_pd = 0;
  logic [1:0]  cmd_sel = 0;
  logic [4:0]  cmd_addr = 0, rd_chan = 0;
  logic [13:0] cmd_data = 0;
  logic        busy_n, pd_active;
  logic [13:0] clr_code, rd_data, rd_gain, rd_offset;

  dac_cmd_ctrl u_dac_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .hw_clr_n(hw_clr_n), .hw_pd(hw_pd),
    .rd_chan(rd_chan), .busy_n(busy_n), .pd_active(pd_active), .clr_code(clr_code),
    .rd_data(rd_data), .rd_gain(rd_gain), .rd_offset(rd_offset)
  );

  // behavioural reference
  int m_data[NCH], m_gain[NCH], m_offs[NCH];
  int m_clr, m_walk, m_left;
  bit m_swpd;
  int checks = 0, fails = 0;
  bit run_chk = 0;
  string cur_req = "R11";

  function automatic void m_regs_default();
    for (int i = 0; i < NCH; i++) begin
      m_data[i] = 0; m_gain[i] = 16'h3FFF; m_offs[i] = 0;
    end
    m_clr = 0; m_swpd = 0;
  endfunction

  always @(posedge clk) begin : model
    bit pd;
    if (!rst_n) begin
      m_regs_default(); m_walk = -1; m_left = 0;
    end else begin
      pd = m_swpd || hw_pd;
      if (m_walk >= 0) begin
        m_data[m_walk] = m_clr;
        m_walk++;
        if (m_walk == NCH) m_walk = -1;
      end else if (m_left > 0) m_left--;
      else if (!hw_clr_n && !pd) m_walk = 0;
      else if (cmd_valid) begin
        if (cmd_sel == 0) begin
          case (int'(cmd_addr))
            1:  if (!pd) m_clr = int'(cmd_data);
            2:  if (!pd) m_walk = 0;
            8:  begin m_swpd = 1; m_left = 1; end
            9:  begin m_swpd = 0; m_left = PWRUP; end
            15: begin m_regs_default(); m_left = RSTC; end
            default: m_left = 1;
          endcase
        end else if (!pd) begin
          case (cmd_sel)
            2'b01: m_gain[cmd_addr] = int'(cmd_data);
            2'b10: m_offs[cmd_addr] = int'(cmd_data);
            default: m_data[cmd_addr] = int'(cmd_data);
          endcase
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // compare away from the edge, then step the read channel
  always @(posedge clk) begin
    #5;
    if (run_chk) begin
      chk("busy_n", int'(busy_n), (m_walk < 0 && m_left == 0) ? 1 : 0);
      chk("pd_active", int'(pd_active), int'(m_swpd || hw_pd));
      chk("clr_code", int'(clr_code), m_clr);
      chk("rd_data", int'(rd_data), m_data[rd_chan]);
      chk("rd_gain", int'(rd_gain), m_gain[rd_chan]);
      chk("rd_offset", int'(rd_offset), m_offs[rd_chan]);
    end
    rd_chan = rd_chan + 5'd1;
  end

  task automatic issue(logic [1:0] s, logic [4:0] a, logic [13:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_sel = s; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_chk = 1;
    cur_req = "R11"; idle(34);

    cur_req = "R1";
    for (int c = 0; c < NCH; c++) issue(2'b11, 5'(c), 14'(c * 311 + 7));
    for (int c = 0; c < NCH; c += 3) issue(2'b01, 5'(c), 14'(c * 97 + 1));
    for (int c = 1; c < NCH; c += 4) issue(2'b10, 5'(c), 14'(16'h1555 ^ c));
    idle(33);

    cur_req = "R2"; issue(2'b00, 5'h01, 14'h2AAA); idle(3);
    cur_req = "R3"; issue(2'b00, 5'h02, 14'h0000); idle(40);

    cur_req = "R9";
    for (int c = 0; c < NCH; c += 2) issue(2'b11, 5'(c), 14'(c + 100));
    issue(2'b00, 5'h02, 14'h0);
    issue(2'b00, 5'h01, 14'h1111);
    issue(2'b11, 5'd4, 14'h0BAD);
    issue(2'b00, 5'h08, 14'h0);
    idle(40);

    cur_req = "R4";
    issue(2'b00, 5'h01, 14'h3FFF);
    for (int c = 0; c < NCH; c += 5) issue(2'b11, 5'(c), 14'(c + 9));
    @(negedge clk);
    hw_clr_n = 0; cmd_valid = 1; cmd_sel = 0; cmd_addr = 5'h01; cmd_data = 14'h0123;
    @(negedge clk);
    hw_clr_n = 1; cmd_valid = 0;
    idle(40);

    cur_req = "R5";
    issue(2'b00, 5'h00, 14'h3FFF); idle(2);
    issue(2'b00, 5'h05, 14'h1234); idle(2);
    issue(2'b00, 5'h1F, 14'h3FFF); idle(34);

    cur_req = "R10";
    for (int c = 0; c < NCH; c += 7) issue(2'b11, 5'(c), 14'(c + 500));
    issue(2'b00, 5'h01, 14'h0042);
    issue(2'b00, 5'h02, 14'h3FFF); idle(40);

    cur_req = "R6";
    issue(2'b00, 5'h08, 14'h3FFF); idle(2);
    issue(2'b11, 5'd3, 14'h0777);
    issue(2'b01, 5'd3, 14'h0777);
    issue(2'b10, 5'd3, 14'h0777);
    issue(2'b00, 5'h01, 14'h0555);
    issue(2'b00, 5'h02, 14'h0);
    @(negedge clk); hw_clr_n = 0; @(negedge clk); hw_clr_n = 1;
    idle(34);

    cur_req = "R7";
    issue(2'b00, 5'h09, 14'h2222); idle(PWRUP + 34);
    hw_pd = 1; idle(2);
    issue(2'b11, 5'd6, 14'h0666);
    issue(2'b00, 5'h09, 14'h0); idle(PWRUP + 2);
    issue(2'b11, 5'd6, 14'h0666);
    @(negedge clk); hw_clr_n = 0; @(negedge clk); hw_clr_n = 1;
    idle(34);
    hw_pd = 0; idle(2);
    issue(2'b11, 5'd6, 14'h0666); idle(34);

    cur_req = "R8";
    issue(2'b01, 5'd9, 14'h0001);
    issue(2'b10, 5'd9, 14'h0002);
    issue(2'b00, 5'h08, 14'h0); idle(2);
    issue(2'b00, 5'h0F, 14'h3FFF);
    idle(RSTC + 34);
    issue(2'b11, 5'd9, 14'h0099); idle(34);

    summary();
    $finish;
  end
endmodule